// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Controller

This block gathers maskable interrupt requests from two kinds of origin and turns them into one request line and a source number for a processor core. A small group of external pins is sampled through a synchronizer, and each pin can be set to one of four trigger codes. Two codes are level conditions, active high or active low. The other two latch an event on a rising or a falling transition. The remaining sources come from on-chip peripherals, which hold an active-high level while they need service.

Firmware programs the block through a four-word register window. One word holds an enable bit per source, one holds the trigger code of each pin, and one shows the pending state of every source. Writing ones to the pending word clears latched edge events. Among the sources that are both pending and enabled, the one with the lowest number is reported. A separate non-maskable input is edge-latched, outranks every maskable source, and stays raised until the core acknowledges it.

Top module: `prog_irq_ctrl`

## Requirements
- R1: After reset, the enable and trigger-code words read zero, so every pin is in active-high level mode. `irq_req`, `nmi_req` and `irq_vec` are 0.
- R2: Internal source i (input `int_irq[i]`) appears as pending bit NUM_EXT+i, combinationally and as an active-high level.
- R3: In level mode, pin e uses code 00 for active high and code 01 for active low. Its pending bit follows the condition with two cycles of synchronizer latency.
- R4: In edge mode, pin e uses code 10 for rising and code 11 for falling. A transition sets a latched pending bit three clock edges after the pin changes, and the bit holds after the pin returns.
- R5: A write to the pending word clears each latched edge bit whose data bit is 1. Data bits of 0, and bits that belong to level-mode or internal sources, have no effect. An edge arriving in the same cycle as the clear wins.
- R6: Enable bits gate only the request. A disabled source still shows as pending.
- R7: `irq_req` is high when some source is both pending and enabled and no non-maskable event is outstanding. `irq_vec` gives the lowest such source number, or 0 when there is none.
- R8: A rising edge on `nmi_in` sets `nmi_req` three clock edges later, with no masking. It holds until an edge samples `nmi_ack` high, and while it is high `irq_req` is low.
- R9: The register map uses `reg_addr` 0 for enable (read/write), 1 for trigger codes (pin e at bits [2e+1:2e], read/write), 2 for pending (read, write-one-to-clear) and 3, which reads 0.
- R10: Any latched edge event of a pin is dropped while that pin is in a level mode. Switching the pin back to an edge code does not revive the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq | input | NUM_EXT | External interrupt pins, asynchronous |
| int_irq | input | NUM_SRC-NUM_EXT | Internal active-high level requests |
| nmi_in | input | 1 | Non-maskable request pin, asynchronous, rising-edge |
| nmi_ack | input | 1 | Core acknowledge of the non-maskable event |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data, combinational on `reg_addr` |
| irq_req | output | 1 | Maskable interrupt request to the core |
| irq_vec | output | $clog2(NUM_SRC) | Number of the winning source |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The bench builds the block with its defaults: 16 sources, 4 of them pins, and a two-stage synchronizer. With that set, the bench can reach every one of the four trigger codes on each pin. It can also test priority between pins and internal sources across the whole vector width, including the top source number 15. The random phase rewrites the trigger-code word while events are in flight, so mode switches can collide with latched edges, write-one-to-clear and non-maskable acknowledges.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    localparam logic [1:0] ADDR_EN   = 2'd0;
    localparam logic [1:0] ADDR_MODE = 2'd1;
    localparam logic [1:0] ADDR_PEND = 2'd2;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = d;
        for (int k = 1; k < STAGES; k++) begin
            st_d[k] = st_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) st_q[k] <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) st_q[k] <= st_d[k];
        end
    end

    assign q = st_q[STAGES-1];

endmodule

// File: rtl/irq_ext_cond.sv
module irq_ext_cond
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_in,
    input  trig_e mode,
    input  logic  clr,
    output logic  pend
);

    typedef struct packed {
        logic prev;
        logic latch;
    } cond_t;

    cond_t st_d, st_q;
    logic  edge_mode;
    logic  event_hit;

    always_comb begin
        edge_mode = mode[1];
        event_hit = 1'b0;
        if (mode == TRIG_RISE) event_hit = sync_in & ~st_q.prev;
        if (mode == TRIG_FALL) event_hit = ~sync_in & st_q.prev;

        st_d      = st_q;
        st_d.prev = sync_in;
        if (!edge_mode) st_d.latch = 1'b0;
        else            st_d.latch = event_hit | (st_q.latch & ~clr);

        if (edge_mode)               pend = st_q.latch;
        else if (mode == TRIG_HIGH)  pend = sync_in;
        else                         pend = ~sync_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a detected transition in edge mode is latched on the next edge
    a_r4_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
        event_hit |=> st_q.latch);

    // R5: a latched event survives unless a clear is written
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latch && edge_mode && !clr) |=> st_q.latch);

    // R10: level mode discards any latched event
    a_r10_level_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> !st_q.latch);

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N  = 16,
    localparam int VW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [VW-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = VW'(i);
        end
    end

endmodule

// File: rtl/prog_irq_ctrl.sv
module prog_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC     = 16,
    parameter int NUM_EXT     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_INT    = NUM_SRC - NUM_EXT,
    localparam int VW         = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_irq,
    input  logic [NUM_INT-1:0] int_irq,
    input  logic               nmi_in,
    input  logic               nmi_ack,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_req,
    output logic [VW-1:0]      irq_vec,
    output logic               nmi_req
);

    typedef struct packed {
        logic [NUM_SRC-1:0]        en;
        trig_e [NUM_EXT-1:0]       mode;
        logic                      nmi_prev;
        logic                      nmi_pend;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_EXT:0]   sync_q;
    logic [NUM_EXT-1:0] ext_s;
    logic               nmi_s;
    logic [NUM_EXT-1:0] ext_pend;
    logic [NUM_EXT-1:0] ext_clr;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] masked;
    logic               any_masked;
    logic [VW-1:0]      win_idx;
    logic               nmi_rise;

    irq_sync #(.W(NUM_EXT + 1), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({nmi_in, ext_irq}),
        .q     (sync_q)
    );

    assign ext_s = sync_q[NUM_EXT-1:0];
    assign nmi_s = sync_q[NUM_EXT];

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
        assign ext_clr[e] = reg_we && (reg_addr == ADDR_PEND) && reg_wdata[e];
        irq_ext_cond cond_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (ext_s[e]),
            .mode    (regs_q.mode[e]),
            .clr     (ext_clr[e]),
            .pend    (ext_pend[e])
        );
    end

    assign pend_vec = {int_irq, ext_pend};
    assign masked   = pend_vec & regs_q.en;

    irq_prio #(.N(NUM_SRC)) prio_i (
        .req (masked),
        .any (any_masked),
        .idx (win_idx)
    );

    always_comb begin
        regs_d   = regs_q;
        nmi_rise = nmi_s & ~regs_q.nmi_prev;

        regs_d.nmi_prev = nmi_s;
        regs_d.nmi_pend = nmi_rise | (regs_q.nmi_pend & ~nmi_ack);

        if (reg_we && reg_addr == ADDR_EN) regs_d.en = reg_wdata;
        if (reg_we && reg_addr == ADDR_MODE) begin
            for (int e = 0; e < NUM_EXT; e++) begin
                regs_d.mode[e] = trig_e'(reg_wdata[2*e +: 2]);
            end
        end

        case (reg_addr)
            ADDR_EN:   reg_rdata = regs_q.en;
            ADDR_MODE: reg_rdata = NUM_SRC'(regs_q.mode);
            ADDR_PEND: reg_rdata = pend_vec;
            default:   reg_rdata = '0;
        endcase

        irq_req = any_masked & ~regs_q.nmi_pend;
        irq_vec = win_idx;
        nmi_req = regs_q.nmi_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // R7: the reported source is pending, enabled, and no lower one qualifies
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (masked[irq_vec] &&
                     ((masked & ~({NUM_SRC{1'b1}} << irq_vec)) == '0)));

    // R6: a request only ever names an enabled source
    a_r6_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> regs_q.en[irq_vec]);

    // R8: the non-maskable event suppresses the maskable request
    a_r8_nmi_excludes: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> !irq_req);

    // R8: the non-maskable request stays up until acknowledged
    a_r8_nmi_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !nmi_ack) |=> nmi_req);

    // R8: an acknowledge with no new edge drops the request
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && nmi_ack && !nmi_rise) |=> !nmi_req);

endmodule

// File: tb/prog_irq_ctrl_tb_top.sv
module prog_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int NE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] ext_irq = '0;
    logic [11:0]   int_irq = '0;
    logic          nmi_in = 1'b0;
    logic          nmi_ack = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic          irq_req;
    logic [3:0]    irq_vec;
    logic          nmi_req;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .int_irq(int_irq),
        .nmi_in(nmi_in), .nmi_ack(nmi_ack), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req)
    );

    // ---------------- reference model built from the requirements ----------
    logic [NE-1:0] m_s1, m_s2, m_p, m_lat;
    logic [7:0]    m_mode;
    logic [NS-1:0] m_en;
    logic          n1, n2, np, npend;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_lat <= '0;
            m_mode <= '0; m_en <= '0;
            n1 <= 1'b0; n2 <= 1'b0; np <= 1'b0; npend <= 1'b0;
        end else begin
            m_s1 <= ext_irq; m_s2 <= m_s1; m_p <= m_s2;
            n1 <= nmi_in; n2 <= n1; np <= n2;
            npend <= (n2 & ~np) | (npend & ~nmi_ack);
            for (int e = 0; e < NE; e++) begin
                logic [1:0] mm;
                logic ev, clr;
                mm  = m_mode[2*e +: 2];
                ev  = (mm == 2'b10 && m_s2[e] && !m_p[e]) ||
                      (mm == 2'b11 && !m_s2[e] && m_p[e]);
                clr = reg_we && reg_addr == 2'd2 && reg_wdata[e];
                m_lat[e] <= mm[1] ? (ev | (m_lat[e] & ~clr)) : 1'b0;
            end
            if (reg_we && reg_addr == 2'd0) m_en <= reg_wdata;
            if (reg_we && reg_addr == 2'd1) m_mode <= reg_wdata[7:0];
        end
    end

    function automatic logic [NS-1:0] exp_pend();
        logic [NS-1:0] p;
        for (int e = 0; e < NE; e++) begin
            logic [1:0] mm;
            mm = m_mode[2*e +: 2];
            p[e] = mm[1] ? m_lat[e] : ((mm == 2'b00) ? m_s2[e] : ~m_s2[e]);
        end
        p[NS-1:NE] = int_irq;
        return p;
    endfunction

    function automatic logic [3:0] exp_vec();
        logic [NS-1:0] m;
        logic [3:0] v;
        m = exp_pend() & m_en;
        v = '0;
        for (int i = NS - 1; i >= 0; i--) if (m[i]) v = 4'(i);
        return v;
    endfunction

    function automatic logic exp_req();
        return !npend && ((exp_pend() & m_en) != '0);
    endfunction

    function automatic logic [NS-1:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0:    return m_en;
            2'd1:    return {8'h00, m_mode};
            2'd2:    return exp_pend();
            default: return '0;
        endcase
    endfunction

    // ---------------- helpers ----------------
    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [NS-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [NS-1:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd4711));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd_check("R1 enable", 2'd0, 16'h0000);
        rd_check("R1 mode", 2'd1, 16'h0000);
        rd_check("R1 pending", 2'd2, 16'h0000);
        check("R1 irq_req", irq_req, 0);
        check("R1 nmi_req", nmi_req, 0);
        check("R1 irq_vec", irq_vec, 0);

        // R3 high level latency
        wr(2'd0, 16'hFFFF);
        ext_irq = 4'b0001;
        step(1);
        check("R3 not yet", irq_req, 0);
        step(1);
        check("R3 high level req", irq_req, 1);
        check("R3 high level vec", irq_vec, 0);
        wr(2'd1, 16'h0001);          // pin0 active low, input high
        #1;
        check("R3 low level idle", irq_req, 0);

        // R4 rising edge on pin1 (pin0 stays low-level quiet)
        wr(2'd1, 16'h0009);
        ext_irq = 4'b0011;
        step(1);
        ext_irq = 4'b0001;
        step(1);
        rd_check("R4 before latch", 2'd2, 16'h0000);
        step(1);
        rd_check("R4 rise latched", 2'd2, 16'h0002);
        check("R4 vec", irq_vec, 1);
        step(3);
        rd_check("R4 held", 2'd2, 16'h0002);

        // R5 write-one-to-clear
        wr(2'd2, 16'h0001);
        rd_check("R5 zero bit keeps", 2'd2, 16'h0002);
        wr(2'd2, 16'h0002);
        rd_check("R5 cleared", 2'd2, 16'h0000);

        // R4 falling edge on pin2
        wr(2'd1, 16'h0039);
        ext_irq = 4'b0101;
        step(4);
        rd_check("R4 fall ignores rise", 2'd2, 16'h0000);
        ext_irq = 4'b0001;
        step(2);
        rd_check("R4 fall not yet", 2'd2, 16'h0000);
        step(1);
        rd_check("R4 fall latched", 2'd2, 16'h0004);

        // R10 level mode drops the event
        wr(2'd1, 16'h0009);
        rd_check("R10 dropped", 2'd2, 16'h0000);
        wr(2'd1, 16'h0039);
        rd_check("R10 not revived", 2'd2, 16'h0000);

        // R2 / R7 / R6 internal sources
        int_irq = 12'h022;           // sources 5 and 9
        #1;
        check("R2 immediate req", irq_req, 1);
        check("R7 lowest vec", irq_vec, 5);
        wr(2'd0, 16'hFFDF);
        check("R7 next vec", irq_vec, 9);
        wr(2'd0, 16'h0000);
        check("R6 masked req", irq_req, 0);
        rd_check("R6 still pending", 2'd2, 16'h0220);
        wr(2'd0, 16'hFFFF);

        // R8 non-maskable
        nmi_in = 1'b1;
        step(1);
        nmi_in = 1'b0;
        step(1);
        check("R8 nmi not yet", nmi_req, 0);
        step(1);
        check("R8 nmi raised", nmi_req, 1);
        check("R8 irq blocked", irq_req, 0);
        step(2);
        check("R8 nmi held", nmi_req, 1);
        nmi_ack = 1'b1;
        step(1);
        nmi_ack = 1'b0;
        check("R8 nmi acked", nmi_req, 0);
        check("R8 irq back", irq_req, 1);

        // R9 map
        rd_check("R9 mode readback", 2'd1, 16'h0039);
        rd_check("R9 enable readback", 2'd0, 16'hFFFF);
        rd_check("R9 spare reads zero", 2'd3, 16'h0000);

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            for (int b = 0; b < NE; b++)
                if ($urandom_range(3) == 0) ext_irq[b] = ~ext_irq[b];
            int_irq = 12'($urandom & $urandom & $urandom);
            if ($urandom_range(15) == 0) nmi_in = ~nmi_in;
            nmi_ack = ($urandom_range(7) == 0);
            reg_we = ($urandom_range(4) == 0);
            reg_addr = 2'($urandom_range(3));
            reg_wdata = 16'($urandom);
            #1;
            check("R2/R9 random read", reg_rdata, exp_rd(reg_addr));
            check("R7 random req", irq_req, exp_req());
            check("R7 random vec", irq_vec, exp_vec());
            check("R8 random nmi", nmi_req, npend);
            step(1);
        end
        reg_we = 1'b0;
        nmi_ack = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule